// File: doc/BRIEF.md
# I2C Paged Write-Buffered Byte Store

This block is the bus-facing slave of a 256-byte non-volatile store, held here as a register array. It watches oversampled SCL and SDA levels, recognises START and STOP conditions, and answers to a 7-bit device address made of a fixed four-bit code and three strap pins. A write transaction carries a one-byte word address and then any number of data bytes. The data bytes are collected in a 16-byte page buffer and are not written to the array until the master ends the transaction with STOP.

After that STOP, a timed internal write cycle starts. During this cycle the busy output is high and the slave does not respond to the bus at all. At the end of the cycle only the buffer slots that the transaction filled are copied into the selected page. A read transaction returns bytes starting at the current address pointer, so a random read is done by sending a write that carries only a word address, and then a read.

Top module: `i2c_page_eeprom`

## Requirements
- R1: The slave acknowledges, by pulling SDA low during the ninth SCL clock, an address byte whose upper seven bits equal binary 1010 followed by strap_a[2], strap_a[1], strap_a[0]. Bit 0 of that byte selects the direction: 0 is write and 1 is read. Any other address byte is not acknowledged and the slave returns to idle.
- R2: In a write transaction, the word address byte and every data byte that follows it are each acknowledged on their ninth clock.
- R3: Bits 7..4 of the word address select the page and bits 3..0 select the byte within that page. Each received data byte goes to the current in-page position, and that position then advances by one.
- R4: When more than 16 data bytes are sent, the in-page position wraps from 15 to 0 without changing the page. A later byte for the same position replaces the earlier one.
- R5: A commit writes only the page positions that received data in the transaction. Every other location of the array keeps its previous value.
- R6: The commit starts only on a STOP that follows at least one data byte. busy rises on the clock after the STOP is detected and stays high for exactly WRITE_CYCLES clocks. The new data can be read once busy is low.
- R7: While busy is high, the slave ignores START, STOP and every byte: it acknowledges nothing and drives nothing.
- R8: A STOP that follows the word address with no data byte starts no commit (busy stays low). It only loads the address pointer with the word address.
- R9: A repeated START in the middle of a transaction returns the slave to idle and discards the buffered data. The address byte that follows is not acknowledged, and the next STOP starts no commit.
- R10: A read transaction sends the byte at the address pointer, MSB first, and then increments the pointer over the full 8 bits (0xFF is followed by 0x00). A master ACK requests the next byte. A master NACK ends the read.
- R11: After reset, busy is low, SDA is released, the pointer is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| strap_a | input | 3 | Strap pins that form the low three bits of the device address |
| sda_oe | output | 1 | When 1, the slave pulls SDA low (open drain) |
| busy | output | 1 | High for the whole internal write cycle |

## Verification
The write path is tested with a single byte, with several bytes that stay inside one page, with a 20-byte burst that wraps in its page, and with an address-only write. Together these separate correct in-page advance and wrap from spill into the next page, and a real commit from a pointer load. A sweep writes two bytes into each of the 16 pages at offsets that move from page to page, with one pair that wraps from offset 15 to 0. A 258-byte read from 0xFE then compares the whole array with a model computed in the bench, which shows up any write to a wrong location and the pointer rollover. Further cases check the abort and deaf conditions: a wrong strap and a wrong device code, a repeated START after buffered data, and a full write attempt sent while the commit is running.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } eep_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WADDR,
        PH_DATA,
        PH_READ
    } eep_phase_e;

    typedef struct packed {
        eep_state_e st;
        eep_phase_e ph;
        logic [3:0] bitc;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       oe;
        logic       got_data;
        logic       racked;
    } eep_ctrl_t;

endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sr;
        logic [SYNC_STAGES-1:0] sda_sr;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_sr   = {s_q.scl_sr[SYNC_STAGES-2:0], scl_i};
        s_d.sda_sr   = {s_q.sda_sr[SYNC_STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_sr[SYNC_STAGES-1];
        s_d.sda_prev = s_q.sda_sr[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o     = s_q.scl_sr[SYNC_STAGES-1];
    assign sda_o     = s_q.sda_sr[SYNC_STAGES-1];
    assign scl_rise  = scl_o & ~s_q.scl_prev;
    assign scl_fall  = ~scl_o & s_q.scl_prev;
    assign start_evt = scl_o & s_q.scl_prev & s_q.sda_prev & ~sda_o;
    assign stop_evt  = scl_o & s_q.scl_prev & ~s_q.sda_prev & sda_o;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int OFF_BITS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              wr_en,
    input  logic [OFF_BITS-1:0]               wr_off,
    input  logic [7:0]                        wr_data,
    output logic [(1<<OFF_BITS)-1:0][7:0]     data_o,
    output logic [(1<<OFF_BITS)-1:0]          mask_o
);
    localparam int SLOTS = 1 << OFF_BITS;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [7:0] byte_d, byte_q;
        logic       fill_d, fill_q;
        logic       hit;

        assign hit = wr_en && (wr_off == OFF_BITS'(g));

        always_comb begin
            byte_d = hit ? wr_data : byte_q;
            fill_d = clr ? 1'b0 : (fill_q | hit);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                fill_q <= 1'b0;
            end else begin
                byte_q <= byte_d;
                fill_q <= fill_d;
            end
        end

        assign data_o[g] = byte_q;
        assign mask_o[g] = fill_q;
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int OFF_BITS     = 4,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [7-OFF_BITS:0]           commit_page,
    input  logic [(1<<OFF_BITS)-1:0][7:0] buf_data,
    input  logic [(1<<OFF_BITS)-1:0]      buf_mask,
    input  logic [7:0]                    rd_addr,
    output logic [7:0]                    rd_data,
    output logic                          busy
);
    localparam int DEPTH     = 256;
    localparam int SLOTS     = 1 << OFF_BITS;
    localparam int PAGE_BITS = 8 - OFF_BITS;
    localparam int CNT_W     = (WRITE_CYCLES < 2) ? 1 : $clog2(WRITE_CYCLES);

    typedef struct packed {
        logic                 busy;
        logic [CNT_W-1:0]     cnt;
        logic [PAGE_BITS-1:0] page;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [7:0] mem [DEPTH];
    logic       done;

    always_comb begin
        t_d  = t_q;
        done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
                done     = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (commit) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(WRITE_CYCLES - 1);
            t_d.page = commit_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (done) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (buf_mask[j]) mem[{t_q.page, j[OFF_BITS-1:0]}] <= buf_data[j];
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = t_q.busy;
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom #(
    parameter int OFF_BITS     = 4,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_a,
    output logic       sda_oe,
    output logic       busy
);
    import eep_pkg::*;

    localparam int SLOTS = 1 << OFF_BITS;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic buf_clr, buf_wr, commit;
    logic [OFF_BITS-1:0]      buf_off;
    logic [SLOTS-1:0][7:0]    buf_data;
    logic [SLOTS-1:0]         buf_mask;
    logic [7:0]               rd_data;
    eep_ctrl_t n, q;

    eep_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_lvl), .sda_o(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    eep_page_buf #(.OFF_BITS(OFF_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
        .wr_off(buf_off), .wr_data(q.sh), .data_o(buf_data), .mask_o(buf_mask)
    );

    eep_store #(.OFF_BITS(OFF_BITS), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .commit_page(q.ptr[7:OFF_BITS]), .buf_data(buf_data),
        .buf_mask(buf_mask), .rd_addr(q.ptr), .rd_data(rd_data), .busy(busy)
    );

    always_comb begin
        n       = q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        buf_off = q.ptr[OFF_BITS-1:0];
        commit  = 1'b0;
        if (busy) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else if (start_evt) begin
            n.oe       = 1'b0;
            n.got_data = 1'b0;
            n.bitc     = '0;
            if (q.st == ST_IDLE) begin
                n.st = ST_RX;
                n.ph = PH_DEV;
            end else begin
                n.st    = ST_IDLE;
                buf_clr = 1'b1;
            end
        end else if (stop_evt) begin
            commit = (q.st != ST_IDLE) && (q.ph == PH_DATA) && q.got_data;
            n.st   = ST_IDLE;
            n.oe   = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_lvl};
                        n.bitc = q.bitc + 4'd1;
                    end else if (scl_fall && q.bitc == 4'd8) begin
                        n.bitc = '0;
                        unique case (q.ph)
                            PH_DEV: begin
                                if (q.sh[7:1] == {DEV_CODE, strap_a}) begin
                                    n.st = ST_ACK;
                                    n.oe = 1'b1;
                                    n.ph = q.sh[0] ? PH_READ : PH_WADDR;
                                end else begin
                                    n.st    = ST_IDLE;
                                    buf_clr = 1'b1;
                                end
                            end
                            PH_WADDR: begin
                                n.ptr   = q.sh;
                                buf_clr = 1'b1;
                                n.ph    = PH_DATA;
                                n.st    = ST_ACK;
                                n.oe    = 1'b1;
                            end
                            PH_DATA: begin
                                buf_wr     = 1'b1;
                                n.ptr      = {q.ptr[7:OFF_BITS],
                                              OFF_BITS'(q.ptr[OFF_BITS-1:0] + 1'b1)};
                                n.got_data = 1'b1;
                                n.st       = ST_ACK;
                                n.oe       = 1'b1;
                            end
                            default: n.st = ST_IDLE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.bitc = '0;
                        if (q.ph == PH_READ) begin
                            n.st  = ST_TX;
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[7];
                            n.ptr = q.ptr + 8'd1;
                        end else begin
                            n.st = ST_RX;
                            n.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitc == 4'd7) begin
                            n.st   = ST_RACK;
                            n.oe   = 1'b0;
                            n.bitc = '0;
                        end else begin
                            n.sh   = {q.sh[6:0], 1'b0};
                            n.oe   = ~q.sh[6];
                            n.bitc = q.bitc + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        n.racked = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.racked) begin
                            n.st  = ST_TX;
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[7];
                            n.ptr = q.ptr + 8'd1;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ph <= PH_DEV;
        end else begin
            q <= n;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
    parameter int WRITE_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sda_oe,
    input logic scl_lvl,
    input logic stop_evt
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R7: nothing is driven on the bus during the internal write
    p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R6: internal write lasts exactly WRITE_CYCLES clocks
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == WRITE_CYCLES);

    // R6: a commit is always started by a STOP
    p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R2: the slave changes its SDA drive only while SCL is low
    p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);
endmodule

bind i2c_page_eeprom eep_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe),
    .scl_lvl(scl_lvl), .stop_evt(stop_evt)
);

// File: tb/i2c_page_eeprom_tb.sv
module i2c_page_eeprom_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int TWR        = 600;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line, sda_oe, busy;
    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] ref_mem [256];

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_page_eeprom #(.OFF_BITS(4), .WRITE_CYCLES(TWR), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_a(STRAP), .sda_oe(sda_oe), .busy(busy)
    );

    task automatic wc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wc(H);
        sda_m = 1'b0; wc(H);
        scl_m = 1'b0; wc(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wc(H);
        scl_m = 1'b1; wc(H);
        sda_m = 1'b0; wc(H);
        scl_m = 1'b0; wc(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(H);
        scl_m = 1'b1; wc(H);
        sda_m = 1'b1;
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wc(H);
            scl_m = 1'b1; wc(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wc(H);
        scl_m = 1'b1; wc(H/2);
        ack = (sda_line == 1'b0);
        wc(H/2);
        scl_m = 1'b0;
    endtask

    task automatic rx_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wc(H);
            scl_m = 1'b1; wc(H/2);
            b[i] = sda_line;
            wc(H/2);
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; wc(H);
        scl_m = 1'b1; wc(H);
        scl_m = 1'b0; wc(2);
        sda_m = 1'b1;
    endtask

    // after a STOP: either a commit of TWR clocks (R6) or no busy at all (R8)
    task automatic expect_commit(input bit want, input string tag);
        int seen = 0;
        int cnt  = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy) seen = 1;
            if (!seen) @(negedge clk);
        end
        chk({tag, " busy after STOP"}, seen, int'(want));
        if (seen) begin
            while (busy) begin cnt++; @(negedge clk); end
            chk({tag, " R6 busy length"}, cnt, TWR);
        end
        wc(H);
    endtask

    task automatic write_seq(input logic [7:0] wa, input int n, input logic [7:0] seed,
                             input string tag);
        bit ack;
        bus_start();
        tx_byte({4'b1010, STRAP, 1'b0}, ack); chk({tag, " R1 dev ack"}, ack, 1);
        tx_byte(wa, ack);                     chk({tag, " R2 waddr ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = seed + 8'(i * 13);
            tx_byte(v, ack); chk({tag, " R2 data ack"}, ack, 1);
            ref_mem[{wa[7:4], 4'(wa[3:0] + 4'(i))}] = v;
        end
        bus_stop();
        expect_commit(n > 0, tag);
    endtask

    task automatic read_seq(input logic [7:0] a, input int n, input string tag);
        bit ack;
        logic [7:0] b;
        bus_start();
        tx_byte({4'b1010, STRAP, 1'b1}, ack); chk({tag, " R1 read dev ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            rx_byte(i < n - 1, b);
            chk({tag, " R10 read data"}, b, ref_mem[8'(a + 8'(i))]);
        end
        bus_stop();
        wc(H);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        wc(5);
        chk("R11 busy in reset", busy, 0);
        chk("R11 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        wc(5);
        chk("R11 busy after reset", busy, 0);

        // R11/R10: pointer starts at 0, array erased
        read_seq(8'h00, 2, "R11 initial");

        // R1: wrong strap and wrong code are not acknowledged
        bus_start();
        tx_byte({4'b1010, 3'b100, 1'b0}, ack); chk("R1 wrong strap nack", ack, 0);
        bus_stop(); wc(H);
        bus_start();
        tx_byte({4'b1011, STRAP, 1'b0}, ack); chk("R1 wrong code nack", ack, 0);
        bus_stop(); wc(H);
        read_seq(8'h02, 1, "R1 pointer untouched");

        // R3/R6: short write, then address-only pointer load (R8)
        write_seq(8'h25, 3, 8'h11, "R3 short");
        write_seq(8'h24, 0, 8'h00, "R8 ptr load");
        read_seq(8'h24, 5, "R3 readback");

        // R4: 20 bytes wrap inside page 3
        write_seq(8'h3C, 20, 8'h80, "R4 wrap");
        write_seq(8'h2F, 0, 8'h00, "R8 ptr load");
        read_seq(8'h2F, 18, "R4 page and neighbours");

        // R5: one byte, rest of page keeps its contents
        write_seq(8'h3A, 1, 8'h77, "R5 partial");
        write_seq(8'h30, 0, 8'h00, "R8 ptr load");
        read_seq(8'h30, 16, "R5 page");

        // R7: a complete write attempt during the commit is ignored
        bus_start();
        tx_byte({4'b1010, STRAP, 1'b0}, ack); chk("R7 setup dev ack", ack, 1);
        tx_byte(8'h48, ack); chk("R7 setup waddr ack", ack, 1);
        tx_byte(8'h5C, ack); chk("R7 setup data ack", ack, 1);
        ref_mem[8'h48] = 8'h5C;
        bus_stop();
        for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
        chk("R7 busy before probe", busy, 1);
        bus_start();
        tx_byte({4'b1010, STRAP, 1'b0}, ack); chk("R7 dev ignored", ack, 0);
        tx_byte(8'h60, ack); chk("R7 waddr ignored", ack, 0);
        tx_byte(8'hAB, ack); chk("R7 data ignored", ack, 0);
        bus_stop();
        chk("R7 still busy after probe", busy, 1);
        while (busy) @(negedge clk);
        wc(H);
        write_seq(8'h48, 0, 8'h00, "R8 ptr load");
        read_seq(8'h48, 1, "R7 committed byte");
        write_seq(8'h60, 0, 8'h00, "R8 ptr load");
        read_seq(8'h60, 1, "R7 probe left no data");

        // R9: repeated START discards buffered bytes
        bus_start();
        tx_byte({4'b1010, STRAP, 1'b0}, ack); chk("R9 dev ack", ack, 1);
        tx_byte(8'h50, ack); chk("R9 waddr ack", ack, 1);
        tx_byte(8'h11, ack); chk("R9 data ack", ack, 1);
        tx_byte(8'h22, ack); chk("R9 data ack", ack, 1);
        bus_rstart();
        tx_byte({4'b1010, STRAP, 1'b0}, ack); chk("R9 after rstart nack", ack, 0);
        bus_stop();
        expect_commit(1'b0, "R9 no commit");
        write_seq(8'h50, 0, 8'h00, "R8 ptr load");
        read_seq(8'h50, 3, "R9 discarded");

        // R3/R5 sweep: two bytes per page, offset moves, page 12 wraps 15->0
        for (int p = 0; p < 16; p++) begin
            logic [7:0] wa;
            wa = {4'(p), 4'((p * 5 + 3) & 15)};
            write_seq(wa, 2, 8'(p * 16 + 1), "R3 sweep");
        end
        // R10: full array read across pointer rollover
        write_seq(8'hFE, 0, 8'h00, "R8 ptr load");
        read_seq(8'hFE, 258, "R10 full sweep");

        summary();
        $finish;
    end
endmodule